// File: doc/BRIEF.md
# FIFO Queuing Lock Manager

This block arbitrates one shared lock among a fixed set of requesters and grants it in strict arrival order. Each acquire draws a ticket by fetch-and-add on a tail index. The ticket, reduced modulo the requester count, names a slot in a small flag array. A slot whose flag is clear is open: its waiter may enter. A slot whose flag is set is blocked.

A waiter whose slot opens takes the lock and closes its own slot behind it. A release opens only the slot after the holder's. The lock therefore passes straight to the next waiter in line, and no shared word is polled by every waiter.

Requesters drive one acquire line and one release line each. They observe their own grant line and the slot they were given. Requests that arrive in the same cycle are ordered by a fixed priority, which a parameter selects. With a slot count equal to the requester count, every requester can be queued at once without two of them sharing a slot.

Top module: `queue_lock_mgr`

## Requirements
- R1: After reset no grant is asserted, every slot index reads 0, the tail is 0, and only slot 0 is open. A single requester that acquires first is granted two clock edges later and is given slot 0.
- R2: An accepted acquire is given the slot equal to the tail modulo NUM_REQ. The tail then advances by the number of acquires accepted in that cycle and wraps from NUM_REQ-1 to 0.
- R3: Acquires accepted in the same cycle receive distinct consecutive slots. With LOW_FIRST=1 the lowest-numbered requester receives the lowest slot. With LOW_FIRST=0 the highest-numbered requester receives it.
- R4: A waiter whose slot is open takes the lock. Its grant goes high at the next clock edge and its own slot becomes blocked. The earliest a grant can follow an acquire is the second edge after the acquire is sampled.
- R5: A release from the holder drops its grant at the sampling edge and opens slot (held slot + 1) mod NUM_REQ at the same edge. The waiter holding that slot is granted one edge later, so no grant is asserted for exactly one cycle in between.
- R6: At most one grant is asserted in any cycle.
- R7: Successive grants go to slots in increasing order modulo NUM_REQ, starting from slot 0 after reset.
- R8: An acquire from a requester that is already waiting or holding is ignored. Its slot, its grant and the tail do not change, and this holds even in the cycle in which it releases.
- R9: A release from a requester that does not hold the lock is ignored. The current grant stays where it is.
- R10: While a requester holds the lock and does not release, its grant stays high and its slot index stays constant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| acq_req | input | NUM_REQ | Per-requester acquire request, sampled each edge |
| rel_req | input | NUM_REQ | Per-requester release request, acted on only for the holder |
| grant | output | NUM_REQ | Per-requester lock grant, registered |
| slot_idx | output | NUM_REQ*$clog2(NUM_REQ) | Slot assigned to each requester. Requester i occupies bits [i*W +: W], where W = $clog2(NUM_REQ) |

## Verification
A release by the holder and a new acquire can land on the same clock edge. When the queue is empty, the newcomer's ticket is the very slot that the release is opening. The bench provokes this by releasing from one requester while another acquires in the same vector. It then expects one idle cycle followed by a grant to the newcomer.

The bench also drives a holder's release together with its own acquire. It judges that case by checking that the grant passes to the next waiter and that a later acquirer still receives the next unused slot, which proves the tail did not move.

// File: rtl/qlm_pkg.sv
package qlm_pkg;

   // per-requester sequencing state
   typedef enum logic [1:0] {
      QS_IDLE = 2'd0,
      QS_WAIT = 2'd1,
      QS_HOLD = 2'd2
   } qstate_e;

endpackage

// File: rtl/qlm_ticket.sv
// Tail index with fetch-and-add: hands consecutive slots to the
// acquires accepted in one cycle, ordered by a fixed priority.
module qlm_ticket #(
   parameter int NUM_REQ   = 8,
   parameter int SLOT_W    = 3,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_REQ-1:0]        accept,
   output logic [NUM_REQ*SLOT_W-1:0] slot_new
);
   localparam int CNT_W = $clog2(NUM_REQ + 1);

   logic [SLOT_W-1:0] tail_q;
   logic [SLOT_W-1:0] tail_d;
   logic [CNT_W-1:0]  total;

   generate
      if (LOW_FIRST) begin : g_low_first
         always_comb begin
            logic [CNT_W-1:0] run;
            run      = '0;
            slot_new = '0;
            for (int i = 0; i < NUM_REQ; i++) begin
               slot_new[i*SLOT_W +: SLOT_W] = tail_q + run[SLOT_W-1:0];
               run = run + CNT_W'(accept[i]);
            end
            total = run;
         end
      end else begin : g_high_first
         always_comb begin
            logic [CNT_W-1:0] run;
            run      = '0;
            slot_new = '0;
            for (int i = NUM_REQ - 1; i >= 0; i--) begin
               slot_new[i*SLOT_W +: SLOT_W] = tail_q + run[SLOT_W-1:0];
               run = run + CNT_W'(accept[i]);
            end
            total = run;
         end
      end
   endgenerate

   assign tail_d = tail_q + total[SLOT_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) tail_q <= '0;
      else        tail_q <= tail_d;
   end

endmodule

// File: rtl/qlm_flags.sv
// Slot flag array: 1 = blocked, 0 = open. Slot 0 starts open.
module qlm_flags #(
   parameter int NUM_REQ = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_REQ-1:0] set_mask,
   input  logic [NUM_REQ-1:0] clr_mask,
   output logic [NUM_REQ-1:0] flags
);
   localparam logic [NUM_REQ-1:0] RESET_FLAGS = ~(NUM_REQ'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) flags <= RESET_FLAGS;
      else        flags <= (flags | set_mask) & ~clr_mask;
   end

endmodule

// File: rtl/qlm_agent.sv
// One requester's view: idle, waiting on its slot, or holding the lock.
module qlm_agent
   import qlm_pkg::*;
#(
   parameter int SLOT_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              rel,
   input  logic [SLOT_W-1:0] slot_in,
   input  logic              slot_open,
   output logic              busy,
   output logic              take,
   output logic              give,
   output logic              holding,
   output logic [SLOT_W-1:0] slot_q
);
   qstate_e state_q;

   assign busy    = (state_q != QS_IDLE);
   assign take    = (state_q == QS_WAIT) && slot_open;
   assign give    = (state_q == QS_HOLD) && rel;
   assign holding = (state_q == QS_HOLD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= QS_IDLE;
         slot_q  <= '0;
      end else begin
         case (state_q)
            QS_IDLE: if (accept) begin
               state_q <= QS_WAIT;
               slot_q  <= slot_in;
            end
            QS_WAIT: if (take) state_q <= QS_HOLD;
            QS_HOLD: if (give) state_q <= QS_IDLE;
            default: state_q <= QS_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/queue_lock_mgr.sv
// Array-based FIFO queuing lock for NUM_REQ requesters.
module queue_lock_mgr #(
   parameter int NUM_REQ   = 8,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic [NUM_REQ-1:0]                   acq_req,
   input  logic [NUM_REQ-1:0]                   rel_req,
   output logic [NUM_REQ-1:0]                   grant,
   output logic [NUM_REQ*$clog2(NUM_REQ)-1:0]   slot_idx
);
   localparam int SLOT_W = $clog2(NUM_REQ);

   generate
      if (NUM_REQ < 2 || (NUM_REQ & (NUM_REQ - 1)) != 0) begin : g_bad_cfg
         $error("queue_lock_mgr: NUM_REQ must be a power of two, at least 2");
      end
   endgenerate

   logic [NUM_REQ-1:0]        busy;
   logic [NUM_REQ-1:0]        accept;
   logic [NUM_REQ-1:0]        take;
   logic [NUM_REQ-1:0]        give;
   logic [NUM_REQ-1:0]        holding;
   logic [NUM_REQ-1:0]        slot_open;
   logic [NUM_REQ-1:0]        flags;
   logic [NUM_REQ-1:0]        set_mask;
   logic [NUM_REQ-1:0]        clr_mask;
   logic [NUM_REQ*SLOT_W-1:0] slot_new;
   logic [SLOT_W-1:0]         slot_q  [NUM_REQ];
   logic [SLOT_W-1:0]         slot_nx [NUM_REQ];

   assign accept = acq_req & ~busy;

   qlm_ticket #(
      .NUM_REQ  (NUM_REQ),
      .SLOT_W   (SLOT_W),
      .LOW_FIRST(LOW_FIRST)
   ) ticket_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .accept  (accept),
      .slot_new(slot_new)
   );

   qlm_flags #(
      .NUM_REQ(NUM_REQ)
   ) flags_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_mask(set_mask),
      .clr_mask(clr_mask),
      .flags   (flags)
   );

   generate
      for (genvar i = 0; i < NUM_REQ; i++) begin : g_agent
         assign slot_open[i] = ~flags[slot_q[i]];
         assign slot_nx[i]   = slot_q[i] + SLOT_W'(1);
         assign slot_idx[i*SLOT_W +: SLOT_W] = slot_q[i];

         qlm_agent #(
            .SLOT_W(SLOT_W)
         ) agent_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .accept   (accept[i]),
            .rel      (rel_req[i]),
            .slot_in  (slot_new[i*SLOT_W +: SLOT_W]),
            .slot_open(slot_open[i]),
            .busy     (busy[i]),
            .take     (take[i]),
            .give     (give[i]),
            .holding  (holding[i]),
            .slot_q   (slot_q[i])
         );
      end
   endgenerate

   // taker blocks its own slot; releaser opens the following slot
   always_comb begin
      set_mask = '0;
      clr_mask = '0;
      for (int i = 0; i < NUM_REQ; i++) begin
         if (take[i]) set_mask[slot_q[i]]  = 1'b1;
         if (give[i]) clr_mask[slot_nx[i]] = 1'b1;
      end
   end

   assign grant = holding;

endmodule

// File: rtl/queue_lock_mgr_chk.sv
module queue_lock_mgr_chk #(
   parameter int NUM_REQ = 8,
   parameter int SLOT_W  = $clog2(NUM_REQ)
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [NUM_REQ-1:0]        rel_req,
   input logic [NUM_REQ-1:0]        grant,
   input logic [NUM_REQ*SLOT_W-1:0] slot_idx
);
   logic [NUM_REQ-1:0] prev_grant;
   logic [NUM_REQ-1:0] new_g;
   logic [SLOT_W-1:0]  new_slot;
   logic [SLOT_W-1:0]  expect_q;

   assign new_g = grant & ~prev_grant;

   always_comb begin
      new_slot = '0;
      for (int i = 0; i < NUM_REQ; i++)
         if (new_g[i]) new_slot = slot_idx[i*SLOT_W +: SLOT_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_grant <= '0;
         expect_q   <= '0;
      end else begin
         prev_grant <= grant;
         if (|new_g) expect_q <= new_slot + SLOT_W'(1);
      end
   end

   a_r6_one_holder: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   a_r5_release_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (|(rel_req & grant)) |=> (grant == '0));

   a_r7_fifo_order: assert property (@(posedge clk) disable iff (!rst_n)
      (|new_g) |-> (new_slot == expect_q));

   generate
      for (genvar i = 0; i < NUM_REQ; i++) begin : g_per_req
         a_r10_slot_held: assert property (@(posedge clk) disable iff (!rst_n)
            (grant[i] && !rel_req[i]) |=>
               (grant[i] && $stable(slot_idx[i*SLOT_W +: SLOT_W])));
      end
   endgenerate

endmodule

bind queue_lock_mgr queue_lock_mgr_chk #(
   .NUM_REQ(NUM_REQ)
) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .rel_req (rel_req),
   .grant   (grant),
   .slot_idx(slot_idx)
);

// File: tb/queue_lock_mgr_tb_top.sv
module queue_lock_mgr_tb_top;
   localparam int N  = 8;
   localparam int SW = 3;
   localparam int NV = 30;

   // {acq_req, rel_req, expected grant after the edge}
   localparam logic [23:0] VEC [NV] = '{
      24'h01_00_00, 24'h00_00_01, 24'h06_00_01, 24'h01_00_01,
      24'h00_01_00, 24'h00_00_02, 24'h00_04_02, 24'h02_02_00,
      24'h00_00_04, 24'h80_04_00, 24'h00_00_80, 24'h7F_00_80,
      24'h00_80_00, 24'h00_00_01, 24'h00_01_00, 24'h00_00_02,
      24'h80_02_00, 24'h00_00_04, 24'h00_04_00, 24'h00_00_08,
      24'h00_08_00, 24'h00_00_10, 24'h00_10_00, 24'h00_00_20,
      24'h00_20_00, 24'h00_00_40, 24'h00_40_00, 24'h00_00_80,
      24'h00_80_00, 24'h00_00_00
   };

   logic                clk = 1'b0;
   logic                rst_n;
   logic [N-1:0]        acq_req;
   logic [N-1:0]        rel_req;
   logic [N-1:0]        grant;
   logic [N*SW-1:0]     slot_idx;
   int                  n_chk = 0;
   int                  n_fail = 0;
   bit                  done = 1'b0;

   always #10 clk = ~clk;

   queue_lock_mgr #(.NUM_REQ(N), .LOW_FIRST(1'b1)) dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .acq_req (acq_req),
      .rel_req (rel_req),
      .grant   (grant),
      .slot_idx(slot_idx)
   );

   function automatic logic [SW-1:0] slot_of(input int r);
      return slot_idx[r*SW +: SW];
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // drive, take one edge, sample mid-high
   task automatic step(input logic [N-1:0] a, input logic [N-1:0] r);
      acq_req = a;
      rel_req = r;
      @(posedge clk);
      #5;
   endtask

   function automatic string tag_of(input int k);
      case (k)
         0, 1:      return "R1 first grant";
         3:         return "R8 acquire while holding";
         6:         return "R9 release by non-holder";
         7:         return "R8 acquire in release cycle";
         4, 9, 12:  return "R5 release gap";
         29:        return "R6 queue drained";
         default:   return "R7 fifo handoff";
      endcase
   endfunction

   initial begin
      rst_n   = 1'b0;
      acq_req = '0;
      rel_req = '0;
      repeat (3) @(posedge clk);
      #5;
      check("R1 reset grant", 32'(grant), 32'h0);
      check("R1 reset slots", 32'(slot_idx), 32'h0);
      rst_n = 1'b1;

      for (int k = 0; k < NV; k++) begin
         step(VEC[k][23:16], VEC[k][15:8]);
         check(tag_of(k), 32'(grant), 32'(VEC[k][7:0]));
         if (k == 2) begin
            check("R3 low index first r1", 32'(slot_of(1)), 32'd1);
            check("R3 low index first r2", 32'(slot_of(2)), 32'd2);
         end
         if (k == 11) begin
            check("R2 wrap r4", 32'(slot_of(4)), 32'd0);
            check("R2 wrap r6", 32'(slot_of(6)), 32'd2);
         end
         if (k == 16) check("R8 tail unmoved r7", 32'(slot_of(7)), 32'd3);
      end

      // tail now 4, slot 4 open
      step(8'h0F, 8'h00);
      check("R4 no grant on acquire edge", 32'(grant), 32'h0);
      for (int r = 0; r < 4; r++)
         check("R2 consecutive slots", 32'(slot_of(r)), 32'(4 + r));
      step(8'h00, 8'h00);
      check("R4 grant second edge", 32'(grant), 32'h01);
      for (int c = 0; c < 3; c++) begin
         step(8'h01, 8'h00);
         check("R10 grant held", 32'(grant), 32'h01);
         check("R10 slot held", 32'(slot_of(0)), 32'd4);
      end

      // mid-run reset
      rst_n = 1'b0;
      step(8'h00, 8'h00);
      check("R1 reset clears grant", 32'(grant), 32'h0);
      rst_n = 1'b1;
      step(8'h20, 8'h00);
      check("R1 slot zero after reset", 32'(slot_of(5)), 32'd0);
      step(8'h00, 8'h00);
      check("R1 granted after reset", 32'(grant), 32'h20);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule